// File: doc/BRIEF.md
# Infrared Raw Symbol Capture Receiver

This peripheral watches a demodulated infrared line and turns each symbol into a pair of durations. The line idles high. A symbol begins when the line falls. It is made of an active low phase (the pulse), followed by a high phase (the space). The symbol closes on the next falling edge, which also starts the next symbol. Durations are counted in units of ten microsecond ticks. The tick comes from a prescaler that divides the input clock by the programmed frequency field plus one, and then by ten. Each closed symbol is packed into one 32-bit word and pushed into a small receive FIFO.

A stream ends when the sum of pulse and space reaches a programmable maximum width. The symbol is then closed with the space measured so far, a timeout event is flagged, and the receiver waits for the next falling edge. Software reads the FIFO occupancy and pops words through a register bus. Software is told about work by three sticky status bits: enough symbols received, timeout and overflow. Each bit is maskable and each can be cleared by a write. A clock-enable input freezes the whole block while it is low. After enabling, a short settling period must elapse before configuration and start are accepted.

Top module: `ir_capture_top`

## Requirements
- R1: After reset the occupancy (0x20) reads 0, status (0x2C) reads 0, busy (0x1C) reads 0, `irq` is low, a pop read on the empty FIFO returns 0, and config (0x04) reads 0x3E80_0080.
- R2: Writing 1 to bit 0 of the enable register (0x00) while it is 0 makes busy read 1 for SETTLE cycles; config writes and start writes made while busy are ignored.
- R3: Falling edges on the line before a write to the start register (0x34) produce no FIFO entries.
- R4: Config fields are max width [31:16], format [15:14], level [13:8], raw [7] and frequency [6:0]. Each word holds the pulse length in bits [15:0] and the space length in bits [31:16], counted in units of 10×(frequency+1) clocks, and is pushed on the falling edge that ends its space.
- R5: When pulse plus space reaches the max width, the symbol is pushed with its current counts and timeout status (bit 9) is set; the next symbol waits for a new falling edge.
- R6: Register 0x20 returns the number of stored words; each read of 0x24 returns the oldest word and removes it.
- R7: Received status (bit 8) sets whenever occupancy is at least level+1, and sets again after a clear while that still holds.
- R8: The FIFO holds 16 words; a push into a full FIFO is dropped, sets overflow status (bit 10), and leaves the stored words intact.
- R9: Writing to the clear register (0x30) with bit 16, 17 or 18 set clears received, timeout or overflow respectively, leaving the others unchanged.
- R10: Mask register (0x28) bits 0..2 mask received, timeout and overflow (1 = masked, reset value 7); status bits 26:24 show the unmasked bits, bits 10:8 the raw bits, and `irq` is high when any unmasked bit is set.
- R11: While `clk_en` is low, no state changes, so frozen cycles are not counted in any duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Block clock enable; low freezes all state |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on 0x24) |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| ir_rx | input | 1 | Demodulated infrared line, idle high |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler or phase counter shows up in the very first popped word after a stream. Its pulse or space field is off by whole units, and a wrong phase assignment swaps the two halves of the word. A misplaced FIFO pointer or count shows as words out of order, or as an occupancy that disagrees with the number of symbols sent, at the first drain. A fault in the status logic shows in the status read right after a stream or a clear: timeout missing, received not re-asserting while the threshold still holds, or overflow not reported after the seventeenth push.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;

    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int DUR_W    = 16;
    localparam int FREQ_W   = 7;
    localparam int UNIT_DIV = 10;

    localparam logic [ADDR_W-1:0] A_ENABLE = 8'h00;
    localparam logic [ADDR_W-1:0] A_CONFIG = 8'h04;
    localparam logic [ADDR_W-1:0] A_BUSY   = 8'h1C;
    localparam logic [ADDR_W-1:0] A_COUNT  = 8'h20;
    localparam logic [ADDR_W-1:0] A_POP    = 8'h24;
    localparam logic [ADDR_W-1:0] A_MASK   = 8'h28;
    localparam logic [ADDR_W-1:0] A_STATUS = 8'h2C;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 8'h30;
    localparam logic [ADDR_W-1:0] A_START  = 8'h34;

    // one captured symbol, space in the upper half
    typedef struct packed {
        logic [DUR_W-1:0] space;
        logic [DUR_W-1:0] pulse;
    } sym_word_t;

    // configuration word, field positions are software visible
    typedef struct packed {
        logic [15:0]       max_width;
        logic [1:0]        fmt;
        logic [5:0]        level;
        logic              raw;
        logic [FREQ_W-1:0] freq;
    } cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PULSE = 2'd1,
        PH_SPACE = 2'd2
    } phase_t;

    // status vector, bit 0 received, bit 1 timeout, bit 2 overflow
    typedef struct packed {
        logic ovf;
        logic tmo;
        logic rcv;
    } irq_vec_t;

    function automatic logic [DUR_W-1:0] sat_inc(input logic [DUR_W-1:0] v);
        return (v == {DUR_W{1'b1}}) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
    parameter int FREQ_W   = 7,
    parameter int UNIT_DIV = 10,
    localparam int DIV_W   = $clog2(UNIT_DIV)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              active,
    input  logic              restart,
    input  logic [FREQ_W-1:0] freq,
    output logic              unit_tick
);
    logic [FREQ_W-1:0] pre_q;
    logic [DIV_W-1:0]  div_q;
    logic              us_tick;

    assign us_tick   = (pre_q >= freq);
    assign unit_tick = active && us_tick && (div_q == DIV_W'(UNIT_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            div_q <= '0;
        end else if (adv) begin
            if (!active || restart) begin
                pre_q <= '0;
                div_q <= '0;
            end else if (us_tick) begin
                pre_q <= '0;
                div_q <= (div_q == DIV_W'(UNIT_DIV - 1)) ? '0 : div_q + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // R4
    div_range_chk: assert property (@(posedge clk) disable iff (rst)
        div_q < DIV_W'(UNIT_DIV));

endmodule

// File: rtl/ir_symbol_meter.sv
module ir_symbol_meter
    import ir_cap_pkg::*;
#(
    parameter int FREQ_W   = 7,
    parameter int UNIT_DIV = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              run,
    input  logic              ir_in,
    input  logic [FREQ_W-1:0] freq,
    input  logic [15:0]       max_width,
    output logic              push,
    output sym_word_t         word,
    output logic              tmo_evt
);
    logic [1:0]       sync_q;
    logic             lvl_d;
    logic             line, fall, rise;
    phase_t           phase_q, phase_d;
    logic [DUR_W-1:0] pulse_q, space_q, pulse_n, space_n, pulse_d, space_d;
    logic [DUR_W:0]   sum;
    logic             hit, tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            lvl_d  <= 1'b1;
        end else if (adv) begin
            sync_q <= {sync_q[0], ir_in};
            lvl_d  <= sync_q[1];
        end
    end

    assign line = sync_q[1];
    assign fall = lvl_d & ~line;
    assign rise = ~lvl_d & line;

    ir_tick_gen #(.FREQ_W(FREQ_W), .UNIT_DIV(UNIT_DIV)) u_tick (
        .clk       (clk),
        .rst       (rst),
        .adv       (adv),
        .active    (phase_q != PH_IDLE),
        .restart   ((phase_q == PH_SPACE) && fall),
        .freq      (freq),
        .unit_tick (tick)
    );

    assign pulse_n = (phase_q == PH_PULSE && tick) ? sat_inc(pulse_q) : pulse_q;
    assign space_n = (phase_q == PH_SPACE && tick) ? sat_inc(space_q) : space_q;
    assign sum     = {1'b0, pulse_n} + {1'b0, space_n};
    assign hit     = sum >= {1'b0, max_width};

    always_comb begin
        phase_d = phase_q;
        pulse_d = pulse_n;
        space_d = space_n;
        push    = 1'b0;
        tmo_evt = 1'b0;
        word    = '{space: space_n, pulse: pulse_n};
        case (phase_q)
            PH_IDLE: begin
                pulse_d = '0;
                space_d = '0;
                if (run && fall) phase_d = PH_PULSE;
            end
            PH_PULSE: begin
                if (hit) begin
                    push    = 1'b1;
                    tmo_evt = 1'b1;
                    phase_d = PH_IDLE;
                end else if (rise) begin
                    phase_d = PH_SPACE;
                end
            end
            PH_SPACE: begin
                if (fall) begin
                    push    = 1'b1;
                    phase_d = PH_PULSE;
                    pulse_d = '0;
                    space_d = '0;
                end else if (hit) begin
                    push    = 1'b1;
                    tmo_evt = 1'b1;
                    phase_d = PH_IDLE;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
        if (!run) begin
            phase_d = PH_IDLE;
            pulse_d = '0;
            space_d = '0;
            push    = 1'b0;
            tmo_evt = 1'b0;
        end
        if (!adv) begin
            push    = 1'b0;
            tmo_evt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            pulse_q <= '0;
            space_q <= '0;
        end else if (adv) begin
            phase_q <= phase_d;
            pulse_q <= pulse_d;
            space_q <= space_d;
        end
    end

    // R4
    pulse_no_space_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PULSE) |-> (space_q == '0));

    // R5
    tmo_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        tmo_evt |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          drop
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          full, do_push, do_pop;

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign drop    = push && !do_push;
    assign dout    = mem[rd_q];
    assign count   = cnt_q;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= nxt(wr_q);
            if (do_pop)  rd_q <= nxt(rd_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    // R8
    fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R8
    drop_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (drop && !pop) |=> $stable(cnt_q));

endmodule

// File: rtl/ir_capture_top.sv
module ir_capture_top
    import ir_cap_pkg::*;
#(
    parameter int          DEPTH    = 16,
    parameter int          SETTLE   = 8,
    parameter logic [6:0]  FREQ_RST = 7'd0,
    localparam int         CNT_W    = $clog2(DEPTH + 1),
    localparam int         BUSY_W   = $clog2(SETTLE + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        clk_en,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        ir_rx,
    output logic        irq
);
    localparam cfg_t CFG_RST = '{max_width: 16'h3E80, fmt: 2'd0, level: 6'd0,
                                 raw: 1'b1, freq: FREQ_RST};

    logic              en_q, run_q;
    logic [BUSY_W-1:0] busy_q;
    logic              busy;
    cfg_t              cfg_q;
    logic [2:0]        mask_q;
    irq_vec_t          st_q, st_d;
    logic              m_push, m_tmo, f_pop, f_empty, f_drop;
    sym_word_t         m_word;
    logic [31:0]       f_dout;
    logic [CNT_W-1:0]  f_cnt;
    logic              wr_en_r, wr_cfg, wr_start, wr_mask, wr_clr;

    assign busy     = (busy_q != '0);
    assign wr_en_r  = clk_en && bus_wr && (bus_addr == A_ENABLE);
    assign wr_cfg   = clk_en && bus_wr && (bus_addr == A_CONFIG);
    assign wr_start = clk_en && bus_wr && (bus_addr == A_START);
    assign wr_mask  = clk_en && bus_wr && (bus_addr == A_MASK);
    assign wr_clr   = clk_en && bus_wr && (bus_addr == A_CLEAR);
    assign f_pop    = clk_en && bus_rd && (bus_addr == A_POP);

    ir_symbol_meter #(.FREQ_W(FREQ_W), .UNIT_DIV(UNIT_DIV)) u_meter (
        .clk       (clk),
        .rst       (rst),
        .adv       (clk_en),
        .run       (run_q && en_q),
        .ir_in     (ir_rx),
        .freq      (cfg_q.freq),
        .max_width (cfg_q.max_width),
        .push      (m_push),
        .word      (m_word),
        .tmo_evt   (m_tmo)
    );

    ir_rx_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (m_push),
        .din   (m_word),
        .pop   (f_pop),
        .dout  (f_dout),
        .count (f_cnt),
        .empty (f_empty),
        .drop  (f_drop)
    );

    always_comb begin
        st_d = st_q;
        if (wr_clr) st_d = st_q & ~irq_vec_t'(bus_wdata[18:16]);
        if (clk_en && (int'(f_cnt) >= int'(cfg_q.level) + 1)) st_d.rcv = 1'b1;
        if (m_tmo)  st_d.tmo = 1'b1;
        if (f_drop) st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            run_q  <= 1'b0;
            busy_q <= '0;
            cfg_q  <= CFG_RST;
            mask_q <= 3'b111;
            st_q   <= '0;
        end else if (clk_en) begin
            st_q <= st_d;
            if (busy) busy_q <= busy_q - 1'b1;
            if (wr_en_r) begin
                en_q <= bus_wdata[0];
                if (bus_wdata[0] && !en_q) busy_q <= BUSY_W'(SETTLE);
                if (!bus_wdata[0]) run_q <= 1'b0;
            end
            if (wr_cfg && !busy) cfg_q <= cfg_t'(bus_wdata);
            if (wr_start && en_q && !busy) run_q <= 1'b1;
            if (wr_mask) mask_q <= bus_wdata[2:0];
        end
    end

    assign irq = |(st_q & ~mask_q);

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_ENABLE: bus_rdata = {31'd0, en_q};
                A_CONFIG: bus_rdata = cfg_q;
                A_BUSY:   bus_rdata = {31'd0, busy};
                A_COUNT:  bus_rdata = 32'(f_cnt);
                A_POP:    bus_rdata = f_empty ? 32'd0 : f_dout;
                A_MASK:   bus_rdata = {29'd0, mask_q};
                A_STATUS: bus_rdata = (32'(st_q & ~mask_q) << 24) | (32'(st_q) << 8);
                default:  bus_rdata = '0;
            endcase
        end
    end

    // R2
    busy_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_cfg) |=> $stable(cfg_q));

    // R9
    clear_tmo_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_clr && bus_wdata[17] && !m_tmo) |=> !st_q.tmo);

endmodule

// File: tb/sim_ir_capture_top.sv
module sim_ir_capture_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clk_en = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ir_rx = 1'b1;
    logic        irq;

    int          n_chk = 0;
    int          n_fail = 0;
    int          pred = 0;
    bit          done = 0;
    logic [31:0] expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_capture_top u0 (
        .clk(clk), .rst(rst), .clk_en(clk_en), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ir_rx(ir_rx), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: plain line activity, no expectation
    task automatic drive(input int lo, input int hi);
        @(negedge clk); ir_rx = 1'b0;
        wait_cyc(lo); ir_rx = 1'b1;
        wait_cyc(hi - 1);
    endtask

    task automatic expect_word(input int p, input int s);
        if (pred < 16) expq.push_back({s[15:0], p[15:0]});
        pred++;
    endtask

    task automatic send_sym(input int p, input int s, input int sc);
        expect_word(p, s);
        drive(p * 10 * sc, s * 10 * sc);
    endtask

    task automatic end_stream(input int p, input int maxw, input int sc);
        expect_word(p, maxw - p);
        drive(p * 10 * sc, (maxw - p) * 10 * sc + 60);
    endtask

    // monitor: pop design output and compare against scoreboard
    task automatic drain(input int n, input string req);
        logic [31:0] v, e;
        rd(8'h20, v);
        chk({req, " count"}, v, n);
        for (int i = 0; i < n; i++) begin
            rd(8'h24, v);
            e = (expq.size() > 0) ? expq.pop_front() : 32'hDEAD_BEEF;
            chk({req, " word"}, v, e);
        end
        pred = 0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        wait_cyc(3);
        rst = 1'b0;
        // R1 reset state
        rd(8'h20, v); chk("R1 count", v, 0);
        rd(8'h2C, v); chk("R1 status", v, 0);
        rd(8'h1C, v); chk("R1 busy", v, 0);
        rd(8'h04, v); chk("R1 config", v, 32'h3E80_0080);
        rd(8'h24, v); chk("R1 empty pop", v, 0);
        #1 chk("R1 irq", {31'd0, irq}, 0);

        // R2 settle window
        wr(8'h00, 32'h1);
        rd(8'h1C, v); chk("R2 busy", v, 1);
        wr(8'h04, 32'h1234_5678);
        rd(8'h04, v); chk("R2 cfg ignored", v, 32'h3E80_0080);
        wait_cyc(12);
        rd(8'h1C, v); chk("R2 busy done", v, 0);
        wr(8'h04, 32'h0028_0180);
        rd(8'h04, v); chk("R4 cfg readback", v, 32'h0028_0180);

        // R3 nothing before start
        drive(30, 20); drive(10, 450);
        rd(8'h20, v); chk("R3 no capture", v, 0);
        wr(8'h34, 32'h0);

        // stream A, freq 0, level 1
        send_sym(3, 2, 1); send_sym(5, 4, 1); send_sym(1, 7, 1); end_stream(2, 40, 1);
        rd(8'h2C, v); chk("R5 R7 raw status", v, 32'h0000_0300);
        #1 chk("R10 irq masked", {31'd0, irq}, 0);
        wr(8'h28, 32'h0);
        rd(8'h2C, v); chk("R10 unmasked status", v, 32'h0300_0300);
        #1 chk("R10 irq", {31'd0, irq}, 1);
        wr(8'h30, 32'h0002_0000);
        rd(8'h2C, v); chk("R9 clear tmo only", v, 32'h0100_0100);
        drain(4, "R4 R6 stream A");
        wr(8'h30, 32'h0001_0000);
        rd(8'h2C, v); chk("R9 clear rcv", v, 0);
        #1 chk("R9 irq low", {31'd0, irq}, 0);

        // stream B, freq 1, level 2
        wr(8'h04, 32'h0028_0281);
        send_sym(2, 3, 2); end_stream(1, 40, 2);
        rd(8'h2C, v); chk("R7 below level", v, 32'h0200_0200);
        end_stream(4, 40, 2);
        rd(8'h2C, v); chk("R7 at level", v, 32'h0300_0300);
        wr(8'h30, 32'h0007_0000);
        rd(8'h2C, v); chk("R7 rcv reasserts", v, 32'h0100_0100);
        drain(3, "R4 stream B");
        wr(8'h30, 32'h0001_0000);

        // overflow, level 63
        wr(8'h04, 32'h0028_3F80);
        for (int i = 0; i < 17; i++) send_sym(1, 1, 1);
        end_stream(1, 40, 1);
        rd(8'h2C, v); chk("R8 ovf status", v, 32'h0600_0600);
        drain(16, "R8 kept words");
        wr(8'h30, 32'h0006_0000);
        rd(8'h2C, v); chk("R9 clear ovf", v, 0);

        // R11 freeze during space
        expect_word(3, 4);
        @(negedge clk); ir_rx = 1'b0;
        wait_cyc(30); ir_rx = 1'b1;
        wait_cyc(20); clk_en = 1'b0;
        wait_cyc(20); clk_en = 1'b1;
        wait_cyc(19);
        end_stream(2, 40, 1);
        drain(2, "R11 freeze");

        done = 1;
        summary();
        $finish;
    end
endmodule